// File: doc/BRIEF.md
# Streaming Squeeze-Excitation Pooling Unit

This block performs the first half of a channel-attention (squeeze-and-excitation) path while convolution results stream past on their way to memory. A copy of each 2×2 output tile is presented on the tile port. The tile carries one small patch for every channel of the current channel group. The unit keeps a running sum per channel of that group. When the last tile of the group arrives, it multiplies each sum by a fixed-point reciprocal of the map area. This gives the average-pooled value for each channel.

Each pooled group is folded into the first fully connected layer as soon as it exists. The pooled values are multiplied by their weight slice, and the products are added into one accumulator per output neuron. Rectification is applied only once every group of the layer has been folded in, and a done flag is raised at that point. Separately, the unit holds the final per-channel excitation vector. It rescales feature tiles that are read back later, one channel per tile.

Top module: `se_squeeze_unit`

## Requirements
- R1: After reset, and in the cycle after a start pulse, `done`, `pool_valid` and all `fc_out` lanes are zero. Reset also clears `out_valid`.
- R2: Each pooled lane `i` (bits `[16i+15:16i]` of `pool_data`) equals the channel's sum multiplied by `recip/65536`. The sum covers all four tile elements of every tile in the group, and element `j` of channel `i` sits at `tile_data[(4i+j)*16 +: 16]`. The product is rounded to nearest with halves toward plus infinity, then saturated to 16-bit signed.
- R3: `pool_valid` is a one-cycle pulse in the cycle after a tile marked `tile_last`. `pool_grp` repeats that tile's group index. The channel sums restart from zero for the next group.
- R4: For every pooled group, output neuron `o` adds the sum over `i` of `pooled_i * w(o,i)`. The weight `w(o,i)` is at `wgt_data[(o*GRP+i)*16 +: 16]`, sampled in the `tile_last` cycle.
- R5: `done` rises two cycles after the `pool_valid` of the CH/GRP-th group since start. At that point, `fc_out` lane `o` (bits `[32o+31:32o]`) shows max(0, accumulated sum) and is zero before then.
- R6: Rectification is deferred to the end. A neuron whose running sum is negative after an early group but positive at the end reports the full signed total.
- R7: `done` and `fc_out` hold until the next start. A start clears all accumulators, so a new pass does not depend on the previous one.
- R8: A write strobe stores `exc_data` as the excitation entry of channel `exc_addr`.
- R9: One cycle after `scl_valid`, `out_valid` is high. Each element `j` of `out_tile` equals `x_j * e/16384`, where `e` is the stored entry for `scl_ch`. The result is rounded to nearest with halves toward plus infinity and saturated to 16-bit signed. `out_valid` is low in every other cycle.
- R10: When a scale and a write to the same channel occur in the same cycle, the scale uses the entry stored before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears pooling and fully connected state |
| recip | input | 16 | Reciprocal of map area, unsigned, scaled by 65536 |
| tile_valid | input | 1 | Tile copy present |
| tile_last | input | 1 | Tile is the last of its group's map |
| tile_grp | input | 1 | Channel group index of the tile |
| tile_data | input | 256 | Four elements per channel for GRP channels |
| wgt_data | input | 256 | NOUT×GRP weight slice, sampled with tile_last |
| pool_valid | output | 1 | Pooled group available |
| pool_grp | output | 1 | Group index of the pooled values |
| pool_data | output | 64 | Pooled value per channel of the group |
| fc_out | output | 128 | Rectified fully connected sums per neuron |
| done | output | 1 | All groups folded and rectified |
| exc_we | input | 1 | Excitation entry write strobe |
| exc_addr | input | 3 | Channel of the written entry |
| exc_data | input | 16 | Excitation value, signed, scaled by 16384 |
| scl_valid | input | 1 | Feature tile to rescale |
| scl_ch | input | 3 | Channel of the feature tile |
| scl_tile | input | 64 | Four signed feature elements |
| out_valid | output | 1 | Rescaled tile valid |
| out_tile | output | 64 | Four rescaled elements |

## Verification
The hardest behaviour to expose from the ports is deferred rectification. An early clamp cannot be seen unless a neuron's running sum actually crosses zero between groups. The stimulus therefore feeds strictly positive activations with negative weights in the first group, then large positive weights in the second. Exact half-way rounding and pooling saturation are reached with constant tiles and a reciprocal chosen to land exactly on .5 or above full scale. The same-cycle write/scale collision is driven explicitly on one channel.

// File: rtl/se_pkg.sv
// Shared helpers for the squeeze-excitation unit.
// Assumes products fit in 63 bits before the shift.
package se_pkg;
    // Round to nearest (half toward +inf), shift right by sh, clamp to dw-bit signed.
    function automatic logic signed [63:0] round_sat(input logic signed [63:0] x,
                                                     input int unsigned sh,
                                                     input int unsigned dw);
        logic signed [63:0] r;
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        r  = (x + (64'sd1 <<< (sh - 1))) >>> sh;
        hi = (64'sd1 <<< (dw - 1)) - 64'sd1;
        lo = -hi - 64'sd1;
        if (r > hi) return hi;
        if (r < lo) return lo;
        return r;
    endfunction
endpackage

// File: rtl/se_pool_accum.sv
// Per-channel tile summation for one channel group, followed by area scaling.
// Assumes all tiles of a group arrive before the next group begins, with the
// final tile flagged; pooled results appear one cycle after that tile.
module se_pool_accum #(
    parameter int DW   = 16,
    parameter int GRP  = 4,
    parameter int ACCW = 32,
    parameter int RCW  = 16,
    parameter int GIDW = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  tile_valid,
    input  logic                  tile_last,
    input  logic [GIDW-1:0]       tile_grp,
    input  logic [GRP*4*DW-1:0]   tile_data,
    input  logic [RCW-1:0]        recip,
    output logic                  pool_valid,
    output logic [GIDW-1:0]       pool_grp,
    output logic [GRP*DW-1:0]     pool_data
);
    import se_pkg::*;

    logic signed [ACCW-1:0] sum_q  [GRP];
    logic signed [ACCW-1:0] sum_nx [GRP];
    logic signed [DW-1:0]   pool_nx[GRP];

    // Add the four tile elements of each channel to its running sum and scale.
    always_comb begin
        logic signed [ACCW-1:0] tot;
        logic signed [63:0]     scaled;
        for (int g = 0; g < GRP; g++) begin
            tot = sum_q[g];
            for (int j = 0; j < 4; j++)
                tot = tot + ACCW'(signed'(tile_data[(4*g+j)*DW +: DW]));
            sum_nx[g]  = tot;
            scaled     = round_sat(64'(tot) * signed'(64'(recip)), RCW, DW);
            pool_nx[g] = scaled[DW-1:0];
        end
    end

    // Hold channel sums; emit pooled group and restart sums on the last tile.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int g = 0; g < GRP; g++) sum_q[g] <= '0;
            pool_valid <= 1'b0;
            pool_grp   <= '0;
            pool_data  <= '0;
        end else begin
            pool_valid <= tile_valid && tile_last;
            if (tile_valid) begin
                if (tile_last) begin
                    for (int g = 0; g < GRP; g++) begin
                        sum_q[g] <= '0;
                        pool_data[g*DW +: DW] <= pool_nx[g];
                    end
                    pool_grp <= tile_grp;
                end else begin
                    for (int g = 0; g < GRP; g++) sum_q[g] <= sum_nx[g];
                end
            end
        end
    end

    p_pool_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_valid && tile_last && !clr) |=> pool_valid);
    p_pool_only_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pool_valid |-> $past(tile_valid && tile_last));
endmodule

// File: rtl/se_fc_fold.sv
// Folds each pooled group into the first fully connected layer's sums.
// Rectifies the sums once all groups of the pass are in.
// Assumes the weight slice is registered alongside the pooled group.
module se_fc_fold #(
    parameter int DW   = 16,
    parameter int GRP  = 4,
    parameter int NOUT = 4,
    parameter int ACCW = 32,
    parameter int NGRP = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    pool_valid,
    input  logic [GRP*DW-1:0]       pool_data,
    input  logic [NOUT*GRP*DW-1:0]  wgt_q,
    output logic [NOUT*ACCW-1:0]    fc_out,
    output logic                    done
);
    localparam int CW = $clog2(NGRP + 1);

    logic signed [ACCW-1:0] acc_q  [NOUT];
    logic signed [ACCW-1:0] acc_nx [NOUT];
    logic [CW-1:0]          gcnt_q;
    logic                   relu_pend;
    logic                   fc_neg;

    // Multiply the pooled group by each neuron's weight slice and accumulate.
    always_comb begin
        logic signed [63:0] tot;
        for (int o = 0; o < NOUT; o++) begin
            tot = 64'(acc_q[o]);
            for (int i = 0; i < GRP; i++)
                tot = tot + 64'(signed'(pool_data[i*DW +: DW])) *
                            64'(signed'(wgt_q[(o*GRP+i)*DW +: DW]));
            acc_nx[o] = tot[ACCW-1:0];
        end
    end

    // Count folded groups, then publish rectified sums one cycle after the last.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int o = 0; o < NOUT; o++) acc_q[o] <= '0;
            gcnt_q    <= '0;
            relu_pend <= 1'b0;
            fc_out    <= '0;
            done      <= 1'b0;
        end else begin
            relu_pend <= 1'b0;
            if (pool_valid && gcnt_q < CW'(NGRP)) begin
                for (int o = 0; o < NOUT; o++) acc_q[o] <= acc_nx[o];
                gcnt_q    <= gcnt_q + 1'b1;
                relu_pend <= (gcnt_q + 1'b1) == CW'(NGRP);
            end
            if (relu_pend) begin
                for (int o = 0; o < NOUT; o++)
                    fc_out[o*ACCW +: ACCW] <= acc_q[o][ACCW-1] ? '0 : acc_q[o];
                done <= 1'b1;
            end
        end
    end

    // Flags any negative lane on the published outputs.
    always_comb begin
        fc_neg = 1'b0;
        for (int o = 0; o < NOUT; o++) fc_neg = fc_neg | fc_out[o*ACCW + ACCW - 1];
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !done);
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gcnt_q <= CW'(NGRP));
    p_relu_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_neg);
endmodule

// File: rtl/se_exc_scale.sv
// Stores the per-channel excitation vector and rescales read-back tiles.
// Assumes the entries are signed fixed point with FRAC fraction bits.
// Output is registered, one cycle after the request.
module se_exc_scale #(
    parameter int DW   = 16,
    parameter int CH   = 8,
    parameter int FRAC = 14,
    parameter int CHW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_we,
    input  logic [CHW-1:0]    exc_addr,
    input  logic [DW-1:0]     exc_data,
    input  logic              scl_valid,
    input  logic [CHW-1:0]    scl_ch,
    input  logic [4*DW-1:0]   scl_tile,
    output logic              out_valid,
    output logic [4*DW-1:0]   out_tile
);
    import se_pkg::*;

    logic signed [DW-1:0] exc_q [CH];
    logic signed [DW-1:0] scl_nx[4];

    // Multiply each tile element by the channel's stored entry, then round and clamp.
    always_comb begin
        logic signed [63:0] r;
        for (int j = 0; j < 4; j++) begin
            r = round_sat(64'(signed'(scl_tile[j*DW +: DW])) * 64'(exc_q[scl_ch]), FRAC, DW);
            scl_nx[j] = r[DW-1:0];
        end
    end

    // Excitation storage: one entry per channel, written by strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CH; c++) exc_q[c] <= '0;
        end else if (exc_we) begin
            exc_q[exc_addr] <= exc_data;
        end
    end

    // Registered rescaled tile.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tile  <= '0;
        end else begin
            out_valid <= scl_valid;
            if (scl_valid)
                for (int j = 0; j < 4; j++) out_tile[j*DW +: DW] <= scl_nx[j];
        end
    end

    p_scale_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_valid |=> out_valid);
    p_scale_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_valid |=> !out_valid);
endmodule

// File: rtl/se_squeeze_unit.sv
// Top of the squeeze-excitation pooling unit. It ties together
// tile pooling, the group-wise fully connected fold and the excitation rescale.
// Assumes the weight slice for a group is valid with that group's last tile.
module se_squeeze_unit #(
    parameter int DW   = 16,
    parameter int CH   = 8,
    parameter int GRP  = 4,
    parameter int NOUT = 4,
    parameter int ACCW = 32,
    parameter int RCW  = 16,
    parameter int FRAC = 14,
    localparam int NGRP = CH / GRP,
    localparam int GIDW = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int CHW  = (CH > 1) ? $clog2(CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [RCW-1:0]          recip,
    input  logic                    tile_valid,
    input  logic                    tile_last,
    input  logic [GIDW-1:0]         tile_grp,
    input  logic [GRP*4*DW-1:0]     tile_data,
    input  logic [NOUT*GRP*DW-1:0]  wgt_data,
    output logic                    pool_valid,
    output logic [GIDW-1:0]         pool_grp,
    output logic [GRP*DW-1:0]       pool_data,
    output logic [NOUT*ACCW-1:0]    fc_out,
    output logic                    done,
    input  logic                    exc_we,
    input  logic [CHW-1:0]          exc_addr,
    input  logic [DW-1:0]           exc_data,
    input  logic                    scl_valid,
    input  logic [CHW-1:0]          scl_ch,
    input  logic [4*DW-1:0]         scl_tile,
    output logic                    out_valid,
    output logic [4*DW-1:0]         out_tile
);
    logic [NOUT*GRP*DW-1:0] wgt_q;

    // Capture the group's weight slice together with its last tile.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wgt_q <= '0;
        else if (tile_valid && tile_last)
            wgt_q <= wgt_data;
    end

    se_pool_accum #(.DW(DW), .GRP(GRP), .ACCW(ACCW), .RCW(RCW), .GIDW(GIDW)) u_pool (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .tile_valid(tile_valid), .tile_last(tile_last), .tile_grp(tile_grp),
        .tile_data(tile_data), .recip(recip),
        .pool_valid(pool_valid), .pool_grp(pool_grp), .pool_data(pool_data)
    );

    se_fc_fold #(.DW(DW), .GRP(GRP), .NOUT(NOUT), .ACCW(ACCW), .NGRP(NGRP)) u_fold (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .pool_valid(pool_valid), .pool_data(pool_data), .wgt_q(wgt_q),
        .fc_out(fc_out), .done(done)
    );

    se_exc_scale #(.DW(DW), .CH(CH), .FRAC(FRAC), .CHW(CHW)) u_scale (
        .clk(clk), .rst_n(rst_n),
        .exc_we(exc_we), .exc_addr(exc_addr), .exc_data(exc_data),
        .scl_valid(scl_valid), .scl_ch(scl_ch), .scl_tile(scl_tile),
        .out_valid(out_valid), .out_tile(out_tile)
    );
endmodule

// File: tb/sim_se_squeeze_unit.sv
module sim_se_squeeze_unit;
    localparam int DW = 16, CH = 8, GRP = 4, NOUT = 4, ACCW = 32;
    localparam int NGRP = CH / GRP;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [15:0] recip = '0;
    logic tile_valid = 1'b0, tile_last = 1'b0;
    logic [0:0] tile_grp = '0;
    logic [GRP*4*DW-1:0] tile_data = '0;
    logic [NOUT*GRP*DW-1:0] wgt_data = '0;
    logic pool_valid, done, out_valid;
    logic [0:0] pool_grp;
    logic [GRP*DW-1:0] pool_data;
    logic [NOUT*ACCW-1:0] fc_out;
    logic exc_we = 1'b0, scl_valid = 1'b0;
    logic [2:0] exc_addr = '0, scl_ch = '0;
    logic [DW-1:0] exc_data = '0;
    logic [4*DW-1:0] scl_tile = '0, out_tile;

    int nchk = 0, nfail = 0;
    longint facc[NOUT];

    always #2 clk = ~clk;

    se_squeeze_unit u0 (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint rsat(input longint x, input int sh);
        longint r = (x + (64'sd1 <<< (sh - 1))) >>> sh;
        if (r > 32767) return 32767;
        if (r < -32768) return -32768;
        return r;
    endfunction

    // Drive one channel group; check its pooled values and update the model.
    task automatic drive_group(input int grp, input int ntile, input int lo, input int hi,
                               input int wlo, input int whi);
        longint sumc[GRP];
        int w[NOUT][GRP];
        longint pref;
        for (int i = 0; i < GRP; i++) sumc[i] = 0;
        for (int o = 0; o < NOUT; o++)
            for (int i = 0; i < GRP; i++) begin
                w[o][i] = wlo + int'($urandom_range(whi - wlo));
                wgt_data[(o*GRP+i)*DW +: DW] = w[o][i][DW-1:0];
            end
        for (int k = 0; k < ntile; k++) begin
            @(negedge clk);
            tile_valid = 1'b1;
            tile_last  = (k == ntile - 1);
            tile_grp   = grp[0:0];
            for (int i = 0; i < GRP; i++)
                for (int j = 0; j < 4; j++) begin
                    int v = lo + int'($urandom_range(hi - lo));
                    tile_data[(4*i+j)*DW +: DW] = v[DW-1:0];
                    sumc[i] += v;
                end
        end
        @(negedge clk);
        tile_valid = 1'b0;
        tile_last  = 1'b0;
        chk("R3 pool_valid after last tile", longint'(pool_valid), 1);
        chk("R3 pool_grp", longint'(pool_grp), grp);
        for (int i = 0; i < GRP; i++) begin
            pref = rsat(sumc[i] * longint'(recip), 16);
            chk("R2 pooled lane", longint'($signed(pool_data[i*DW +: DW])), pref);
            for (int o = 0; o < NOUT; o++) facc[o] += pref * w[o][i];
        end
    endtask

    // Check done timing and rectified outputs after the final group (R5).
    task automatic finish_run(input string tag);
        @(negedge clk);
        chk({"R3 pool pulse ends ", tag}, longint'(pool_valid), 0);
        chk({"R5 done not early ", tag}, longint'(done), 0);
        @(negedge clk);
        chk({"R5 done ", tag}, longint'(done), 1);
        for (int o = 0; o < NOUT; o++)
            chk({"R5 R6 fc lane ", tag}, longint'($signed(fc_out[o*ACCW +: ACCW])),
                (facc[o] < 0) ? 0 : facc[o]);
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int o = 0; o < NOUT; o++) facc[o] = 0;
        chk("R1 done clear after start", longint'(done), 0);
        chk("R1 fc clear after start", longint'(fc_out != '0), 0);
    endtask

    task automatic t_reset();
        chk("R1 reset done", longint'(done), 0);
        chk("R1 reset pool_valid", longint'(pool_valid), 0);
        chk("R1 reset fc_out", longint'(fc_out != '0), 0);
        chk("R1 reset out_valid", longint'(out_valid), 0);
    endtask

    // R2 R4 R5: random data and signed weights, uneven tile counts.
    task automatic t_basic();
        recip = 16'd4096;
        do_start();
        drive_group(0, 3, -200, 200, -300, 300);
        drive_group(1, 6, -200, 200, -300, 300);
        finish_run("basic");
    endtask

    // R6: sum goes negative after group 0, ends positive.
    task automatic t_relu_late();
        recip = 16'd4096;
        do_start();
        drive_group(0, 4, 50, 100, -100, -50);
        drive_group(1, 4, 50, 100, 200, 300);
        finish_run("late relu");
        do_start();
        drive_group(0, 4, 50, 100, -100, -50);
        drive_group(1, 4, 50, 100, -100, -50);
        finish_run("all negative");
    endtask

    // R2: exact half rounding and saturation.
    task automatic t_round();
        recip = 16'd8192;
        do_start();
        drive_group(0, 1, -3, -3, 0, 0);
        drive_group(1, 1, 3, 3, 0, 0);
        finish_run("half");
        recip = 16'hFFFF;
        do_start();
        drive_group(0, 4, 32767, 32767, 0, 0);
        drive_group(1, 4, -32768, -32768, 0, 0);
        finish_run("sat");
    endtask

    // R7: done holds while idle; start mid-pass discards earlier groups.
    task automatic t_restart();
        recip = 16'd2048;
        do_start();
        drive_group(0, 2, -100, 100, -50, 50);
        drive_group(1, 2, -100, 100, -50, 50);
        finish_run("before idle");
        repeat (5) @(negedge clk);
        chk("R7 done holds", longint'(done), 1);
        do_start();
        drive_group(0, 2, 500, 900, 40, 90);
        do_start();
        drive_group(1, 3, 10, 40, 1, 9);
        drive_group(0, 3, 10, 40, 1, 9);
        finish_run("after restart");
    endtask

    task automatic exc_write(input int ch, input int val);
        @(negedge clk);
        exc_we = 1'b1; exc_addr = ch[2:0]; exc_data = val[DW-1:0];
        @(negedge clk);
        exc_we = 1'b0;
    endtask

    task automatic scale_chk(input int ch, input int e, input int x0, input int x1,
                             input int x2, input int x3, input string req);
        int xs[4] = '{x0, x1, x2, x3};
        @(negedge clk);
        scl_valid = 1'b1; scl_ch = ch[2:0];
        for (int j = 0; j < 4; j++) scl_tile[j*DW +: DW] = xs[j][DW-1:0];
        @(negedge clk);
        scl_valid = 1'b0;
        chk({req, " out_valid"}, longint'(out_valid), 1);
        for (int j = 0; j < 4; j++)
            chk(req, longint'($signed(out_tile[j*DW +: DW])), rsat(longint'(xs[j]) * e, 14));
        @(negedge clk);
        chk({req, " out_valid pulse"}, longint'(out_valid), 0);
    endtask

    // R8 R9: entries per channel, rounding and saturation of rescale.
    task automatic t_scale();
        exc_write(2, 12288);
        exc_write(5, -8192);
        exc_write(7, 32767);
        scale_chk(2, 12288, 100, -100, 3, -2, "R8 R9 ch2");
        scale_chk(5, -8192, 101, -101, 7, 0, "R8 R9 ch5");
        scale_chk(7, 32767, 32767, -32768, 16000, -1, "R9 saturation");
    endtask

    // R10: same-cycle write and scale of one channel uses the old entry.
    task automatic t_collide();
        exc_write(3, 16384);
        @(negedge clk);
        exc_we = 1'b1; exc_addr = 3'd3; exc_data = 16'd8192;
        scl_valid = 1'b1; scl_ch = 3'd3; scl_tile = {16'd4, 16'd40, 16'd400, 16'd1000};
        @(negedge clk);
        exc_we = 1'b0; scl_valid = 1'b0;
        chk("R10 old entry lane0", longint'($signed(out_tile[15:0])), 1000);
        chk("R10 old entry lane3", longint'($signed(out_tile[63:48])), 4);
        scale_chk(3, 8192, 1000, 400, 40, 4, "R10 new entry after");
    endtask

    initial begin
        for (int o = 0; o < NOUT; o++) facc[o] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_relu_late();
        t_round();
        t_restart();
        t_scale();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule